// File: doc/BRIEF.md
# Page-Mapped Multi-Bank Video Memory Router

The router sits between one requester (a processor or a display engine) and a set of nine physical memory banks that share one logical video address window. The window is cut into equal pages. For each page a mapping table holds a bitmask with one bit per bank, which says which banks currently back that page. Software (or a neighbouring control block) loads the table through a simple write port. Filling the table from control-register settings is left to that neighbour.

Several banks may back a page at once. A read then returns the bitwise OR of the data held by every backing bank. A write is copied into all of them. Each bank is smaller than the window and takes only as many low address bits as its own size needs, so a bank repeats through every page it is mapped to. A region parameter lists the banks that this window may reach at all. Mask bits for any other bank are ignored. Reads are registered: the data appears one cycle after the request, with a one-cycle valid strobe. A small two-state response machine produces that strobe. Its states are `ST_IDLE` (no read data) and `ST_RESP` (read data valid this cycle). It moves from `ST_IDLE` to `ST_RESP` on an accepted read, stays in `ST_RESP` on a back-to-back read, and returns to `ST_IDLE` on any cycle with no accepted read.

Top module: `vram_page_router`

## Requirements
- R1: After reset every page mask is zero, `rd_valid` is low and `rd_data` is zero, so a read of any address returns zero.
- R2: The page index is `acc_addr[8:4]` (32 pages of 16 words each). A mapping on one page does not change reads of another page.
- R3: A read accepted in cycle N gives `rd_valid` high with its data in cycle N+1. `rd_valid` is low in every cycle that does not follow an accepted read. Back-to-back reads each get their own valid cycle.
- R4: A read returns the bitwise OR of the words stored at the read offset in every bank whose mask bit is set. Mask bit k selects bank k: bit 0 = bank A, bit 1 = B, bit 2 = C, bit 3 = D, bit 4 = E, bit 5 = F, bit 6 = G, bit 7 = H, bit 8 = I.
- R5: A read of a page whose effective mask is empty returns zero with `rd_valid` high. `rd_data` is zero whenever `rd_valid` is low.
- R6: A write stores `acc_wdata` into every bank whose mask bit is set for the page.
- R7: The offset inside a bank is the low bits of `acc_addr`, sized to that bank: 7 bits for A–D, 6 for E, 5 for H and 4 for F, G and I. A bank mapped on several pages shows the same words on each of them.
- R8: Mask bits for banks outside the `ALLOWED` parameter (default 9'h07F, banks A–G) have no effect on reads or writes.
- R9: A mask-table write takes effect from the next cycle. An access in the same cycle as the table write uses the old mask.
- R10: If `acc_rd` and `acc_wr` are both high, the write is performed and the read is dropped (no `rd_valid` in the next cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Mask-table write strobe |
| map_page | input | 5 | Page whose mask is written |
| map_mask | input | 9 | New bank mask for that page |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| acc_addr | input | 9 | Word address in the window (page and offset) |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid strobe |
| rd_data | output | 16 | OR-combined read data |

## Verification
The assertions assume that the requester never raises `acc_rd` and `acc_wr` together except where R10's rule applies. They also assume that a read only targets words that were written in every bank the page selects, because bank storage has no reset. The stimulus writes each offset before reading it, changes masks only between accesses except in the directed same-cycle case for R9, and raises both strobes together in only one directed cycle, which checks the dropped-read rule.

// File: rtl/vram_route_pkg.sv
package vram_route_pkg;

    localparam int unsigned NUM_BANKS = 9;

    // bank positions in a page mask
    localparam int unsigned BK_A = 0;
    localparam int unsigned BK_E = 4;
    localparam int unsigned BK_H = 7;
    localparam int unsigned BK_I = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_t;

endpackage

// File: rtl/page_mask_table.sv
module page_mask_table #(
    parameter int unsigned PAGE_W = 5,
    parameter int unsigned NB     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [NB-1:0]     wr_mask,
    input  logic [PAGE_W-1:0] rd_page,
    output logic [NB-1:0]     rd_mask
);
    localparam int unsigned NPAGES = 1 << PAGE_W;

    logic [NB-1:0] ent [NPAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPAGES; p++) ent[p] <= '0;
        end else if (we) begin
            ent[wr_page] <= wr_mask;
        end
    end

    // old mask visible during the write cycle
    assign rd_mask = ent[rd_page];

    // R9: a written entry holds the new mask one cycle later
    a_r9_mask_update: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ent[$past(wr_page)] == $past(wr_mask));

endmodule

// File: rtl/bank_ram.sv
module bank_ram #(
    parameter int unsigned AW = 7,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // output is zero unless this bank was selected for the read
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (re) q <= mem[addr];
        else         q <= '0;
    end

    // R6: a write lands in this bank's storage
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(addr)] == $past(wdata));

    // R5: an unselected bank contributes nothing to the next cycle
    a_r5_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> q == '0);

endmodule

// File: rtl/vram_page_router.sv
module vram_page_router
    import vram_route_pkg::*;
#(
    parameter int unsigned PAGE_W     = 5,
    parameter int unsigned PAGE_SHIFT = 4,
    parameter int unsigned DW         = 16,
    parameter int unsigned AW_ABCD    = 7,
    parameter int unsigned AW_E       = 6,
    parameter int unsigned AW_FG      = 4,
    parameter int unsigned AW_H       = 5,
    parameter int unsigned AW_I       = 4,
    parameter logic [8:0]  ALLOWED    = 9'h07F
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          map_we,
    input  logic [PAGE_W-1:0]             map_page,
    input  logic [NUM_BANKS-1:0]          map_mask,
    input  logic                          acc_rd,
    input  logic                          acc_wr,
    input  logic [PAGE_W+PAGE_SHIFT-1:0]  acc_addr,
    input  logic [DW-1:0]                 acc_wdata,
    output logic                          rd_valid,
    output logic [DW-1:0]                 rd_data
);
    localparam int unsigned ADDR_W = PAGE_W + PAGE_SHIFT;

    logic [PAGE_W-1:0]    cur_page;
    logic [NUM_BANKS-1:0] raw_mask;
    logic [NUM_BANKS-1:0] sel;
    logic                 rd_take;
    logic [DW-1:0]        bank_q [NUM_BANKS];

    assign cur_page = acc_addr[ADDR_W-1:PAGE_SHIFT];
    assign rd_take  = acc_rd & ~acc_wr;
    assign sel      = raw_mask & ALLOWED;

    page_mask_table #(.PAGE_W(PAGE_W), .NB(NUM_BANKS)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (map_we),
        .wr_page (map_page),
        .wr_mask (map_mask),
        .rd_page (cur_page),
        .rd_mask (raw_mask)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int unsigned AW =
            (b < BK_E)  ? AW_ABCD :
            (b == BK_E) ? AW_E    :
            (b == BK_H) ? AW_H    :
            (b == BK_I) ? AW_I    : AW_FG;

        if (AW > ADDR_W) begin : g_bad
            initial $error("bank offset wider than window address");
        end

        bank_ram #(.AW(AW), .DW(DW)) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (acc_wr & sel[b]),
            .re    (rd_take & sel[b]),
            .addr  (acc_addr[AW-1:0]),
            .wdata (acc_wdata),
            .q     (bank_q[b])
        );
    end

    // wired-OR combination of all bank outputs
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) rd_data = rd_data | bank_q[b];
    end

    // response state machine
    resp_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (rd_take)  state_nx = ST_RESP;
            ST_RESP: if (!rd_take) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_valid = 1'b0;
        unique case (state)
            ST_IDLE: rd_valid = 1'b0;
            ST_RESP: rd_valid = 1'b1;
            default: rd_valid = 1'b0;
        endcase
    end

    // R3: every accepted read is answered in the next cycle
    a_r3_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_wr) |=> rd_valid);

    // R3: no valid strobe without a read one cycle earlier
    a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rd || acc_wr) |=> !rd_valid);

    // R5: data bus is quiet outside a response
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0);

    // R10: a write in the same cycle cancels the read
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> !rd_valid);

endmodule

// File: tb/vram_page_router_test.sv
`timescale 1ns/1ps
module vram_page_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_we = 1'b0;
    logic [4:0]  map_page = '0;
    logic [8:0]  map_mask = '0;
    logic        acc_rd = 1'b0;
    logic        acc_wr = 1'b0;
    logic [8:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vram_page_router uut (
        .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_page(map_page),
        .map_mask(map_mask), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    localparam logic [1:0] OP_M = 2'd0, OP_W = 2'd1, OP_R = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [8:0]  addr;   // page in low bits for OP_M
        logic [15:0] data;   // mask for OP_M, expected for OP_R
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        '{OP_M, 9'h000, 16'h0001, 4'd4},  // page0 -> A
        '{OP_W, 9'h005, 16'h1111, 4'd6},
        '{OP_R, 9'h005, 16'h1111, 4'd4},  // R4 single bank
        '{OP_M, 9'h001, 16'h0002, 4'd2},  // page1 -> B
        '{OP_W, 9'h013, 16'h2222, 4'd6},
        '{OP_R, 9'h013, 16'h2222, 4'd2},  // R2 page decode
        '{OP_M, 9'h008, 16'h0001, 4'd7},  // page8 -> A
        '{OP_R, 9'h085, 16'h1111, 4'd7},  // R7 A wraps at 7 bits
        '{OP_M, 9'h002, 16'h000C, 4'd6},  // page2 -> C|D
        '{OP_W, 9'h021, 16'h00F0, 4'd6},
        '{OP_M, 9'h002, 16'h0004, 4'd6},
        '{OP_R, 9'h021, 16'h00F0, 4'd6},  // R6 copy in C
        '{OP_M, 9'h002, 16'h0008, 4'd6},
        '{OP_R, 9'h021, 16'h00F0, 4'd6},  // R6 copy in D
        '{OP_M, 9'h003, 16'h0010, 4'd4},  // page3 -> E
        '{OP_W, 9'h031, 16'h0A00, 4'd6},
        '{OP_M, 9'h003, 16'h0020, 4'd4},  // page3 -> F
        '{OP_W, 9'h031, 16'h0050, 4'd6},
        '{OP_M, 9'h003, 16'h0030, 4'd4},  // page3 -> E|F
        '{OP_R, 9'h031, 16'h0A50, 4'd4},  // R4 OR of two banks
        '{OP_M, 9'h004, 16'h0000, 4'd5},
        '{OP_R, 9'h040, 16'h0000, 4'd5},  // R5 empty mask
        '{OP_M, 9'h005, 16'h0080, 4'd8},  // page5 -> H (not allowed)
        '{OP_W, 9'h051, 16'hDEAD, 4'd8},
        '{OP_R, 9'h051, 16'h0000, 4'd8},  // R8 H bit ignored
        '{OP_M, 9'h005, 16'h0081, 4'd8},  // page5 -> A|H
        '{OP_W, 9'h051, 16'h3333, 4'd8},
        '{OP_R, 9'h051, 16'h3333, 4'd8},  // R8 only A answers
        '{OP_M, 9'h006, 16'h0020, 4'd7},  // page6 -> F
        '{OP_R, 9'h061, 16'h0050, 4'd7},  // R7 F wraps at 4 bits
        '{OP_R, 9'h005, 16'h1111, 4'd2},  // R2 page0 untouched
        '{OP_M, 9'h00F, 16'h0010, 4'd7},  // page15 -> E
        '{OP_R, 9'h0F1, 16'h0A00, 4'd7}   // R7 E wraps at 6 bits
    };

    task automatic chk(input bit ok, input int req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic do_map(input logic [4:0] pg, input logic [8:0] m);
        @(negedge clk);
        map_we = 1'b1; map_page = pg; map_mask = m;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic do_write(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic do_read(input logic [8:0] a, input logic [15:0] e, input int req);
        @(negedge clk);
        acc_rd = 1'b1; acc_addr = a;
        @(negedge clk);
        acc_rd = 1'b0;
        chk(rd_valid === 1'b1 && rd_data === e, req, rd_data, e);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rd_valid === 1'b0, 1, {15'd0, rd_valid}, 16'd0);
        chk(rd_data === 16'h0000, 1, rd_data, 16'h0000);
        rst_n = 1'b1;
        do_read(9'h005, 16'h0000, 1);   // R1 all masks empty

        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].op)
                OP_M: do_map(VECS[i].addr[4:0], VECS[i].data[8:0]);
                OP_W: do_write(VECS[i].addr, VECS[i].data);
                default: do_read(VECS[i].addr, VECS[i].data, int'(VECS[i].req));
            endcase
        end

        // R9: access in the table-write cycle sees the old mask
        do_map(5'd9, 9'h001);
        do_write(9'h095, 16'h4444);
        @(negedge clk);
        map_we = 1'b1; map_page = 5'd9; map_mask = 9'h000;
        acc_rd = 1'b1; acc_addr = 9'h095;
        @(negedge clk);
        map_we = 1'b0; acc_rd = 1'b0;
        chk(rd_valid === 1'b1 && rd_data === 16'h4444, 9, rd_data, 16'h4444);
        do_read(9'h095, 16'h0000, 9);   // R9 new mask now active

        // R10: read and write together -> write done, read dropped
        do_map(5'd9, 9'h001);
        @(negedge clk);
        acc_rd = 1'b1; acc_wr = 1'b1; acc_addr = 9'h095; acc_wdata = 16'h5555;
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0;
        chk(rd_valid === 1'b0 && rd_data === 16'h0000, 10, rd_data, 16'h0000);
        do_read(9'h095, 16'h5555, 10);

        // R3: back-to-back reads, then idle
        @(negedge clk);
        acc_rd = 1'b1; acc_addr = 9'h005;
        @(negedge clk);
        acc_addr = 9'h095;
        chk(rd_valid === 1'b1 && rd_data === 16'h1111, 3, rd_data, 16'h1111);
        @(negedge clk);
        acc_rd = 1'b0;
        chk(rd_valid === 1'b1 && rd_data === 16'h5555, 3, rd_data, 16'h5555);
        @(negedge clk);
        chk(rd_valid === 1'b0 && rd_data === 16'h0000, 3, {15'd0, rd_valid}, 16'h0000);

        finished = 1'b1;
        summary();
    end

endmodule